// File: doc/BRIEF.md
# Oversampling Baud Tick Generator

This block turns a fast reference clock into the timing enables a serial transmitter and receiver need. The reference first passes through a prescaler that either lets every cycle through or only every fourth one. A 16-bit programmable divisor then counts those prescaled cycles, and every time it completes a count it produces a one-cycle 16x oversampling enable. A second stage counts sixteen of those enables to produce the 1x bit-rate enable. The bit rate is therefore the reference frequency divided by the prescale ratio, by 16 and by the divisor. For example, a 7.3728 MHz reference with divisor 1 gives 460.8 kbit/s with no prescaling and 115.2 kbit/s with divide-by-4. With divide-by-4 and divisor 2304, the same reference gives 50 bit/s.

Software writes the divisor one byte at a time, through a high-byte strobe and a low-byte strobe that share one data bus. The prescale choice comes from a strap input while reset is held, and a later register write can override it. The divisor counter is a two-state machine. GEN_IDLE means no divisor is programmed and the generator is silent. GEN_RUN means the counter is dividing. The transitions are START, taken from GEN_IDLE when a nonzero divisor is present; RELOAD, taken at each terminal count in GEN_RUN while the divisor is nonzero; and STOP, taken at a terminal count in GEN_RUN when the divisor register holds zero.

Top module: `baud_rate_gen`

## Requirements
- R1: While reset is held and after it is released with the divisor still zero, `tick16` and `tick1` are low. Both divisor bytes reset to 0.
- R2: While the programmed divisor is 0, no `tick16` or `tick1` pulse is produced.
- R3: With the prescaler select at 0 and divisor D, `tick16` pulses once every D clock cycles.
- R4: With the prescaler select at 1 and divisor D, `tick16` pulses once every 4*D clock cycles.
- R5: During reset, the prescaler select takes the value of `strap_div4`.
- R6: A cycle with `presc_we` high loads `presc_val` into the prescaler select. The new ratio applies to all following intervals.
- R7: The divisor is formed from `div_wdata` written with `div_hi_we` into bits 15:8 and with `div_lo_we` into bits 7:0. Divisor 0x0900 with divide-by-4 gives a `tick16` period of 9216 cycles.
- R8: A divisor written during an interval does not shorten that interval. The interval in progress finishes at its old length, and the next interval uses the new value.
- R9: When the period is longer than one cycle, `tick16` is high for exactly one cycle per period.
- R10: `tick1` is high only in cycles where `tick16` is high, once per 16 `tick16` pulses, so its period is 16 times the `tick16` period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_div4 | input | 1 | Prescaler default, sampled while reset is held (1 = divide-by-4) |
| presc_we | input | 1 | Write strobe for the prescaler select |
| presc_val | input | 1 | New prescaler select (1 = divide-by-4, 0 = divide-by-1) |
| div_hi_we | input | 1 | Write strobe for divisor bits 15:8 |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0 |
| div_wdata | input | 8 | Divisor byte data |
| tick16 | output | 1 | 16x oversampling enable |
| tick1 | output | 1 | 1x bit-rate enable |

## Verification
Some properties are checked every cycle. These are the counter range in GEN_RUN, silence after GEN_IDLE, the link from each `tick16` pulse to a prescaler enable, the gap after each divide-by-4 enable, single-cycle `tick16` pulses, and `tick1` falling only on a `tick16` cycle. The actual period lengths can only be shown by the bench's scenarios. The same holds for the strap default, runtime prescaler changes, the byte assembly of the divisor, and the rule that a mid-interval write takes effect only at the next terminal count. The bench measures these as cycle distances between pulses.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_t;
endpackage

// File: rtl/baud_presc.sv
module baud_presc #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_div4,
    input  logic presc_we,
    input  logic presc_val,
    output logic pre_en
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic          sel;
    logic [PW-1:0] pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= strap_div4;
            pc  <= '0;
        end else begin
            if (presc_we)
                sel <= presc_val;
            pc <= (pc == PW'(RATIO - 1)) ? '0 : pc + 1'b1;
        end
    end

    assign pre_en = sel ? (pc == PW'(RATIO - 1)) : 1'b1;

    // R4: a divided enable is always followed by a quiet cycle
    p_presc_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && pre_en) |=> (!pre_en || !sel));
endmodule

// File: rtl/baud_divctr.sv
module baud_divctr
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pre_en,
    input  logic               div_hi_we,
    input  logic               div_lo_we,
    input  logic [DIV_W/2-1:0] div_wdata,
    output logic               fire,
    output logic               tick16
);
    localparam int HALF = DIV_W / 2;

    gen_state_t       state, state_nx;
    logic [DIV_W-1:0] div_reg;
    logic [DIV_W-1:0] act_div, act_div_nx;
    logic [DIV_W-1:0] cnt, cnt_nx;
    logic             terminal;

    assign terminal = (cnt == act_div - 1'b1);

    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt;
        act_div_nx = act_div;
        fire       = 1'b0;
        unique case (state)
            GEN_IDLE: begin
                if (div_reg != '0) begin          // START
                    state_nx   = GEN_RUN;
                    cnt_nx     = '0;
                    act_div_nx = div_reg;
                end
            end
            GEN_RUN: begin
                if (pre_en) begin
                    if (terminal) begin
                        fire   = 1'b1;
                        cnt_nx = '0;
                        if (div_reg == '0)        // STOP
                            state_nx = GEN_IDLE;
                        else                      // RELOAD
                            act_div_nx = div_reg;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: state_nx = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= GEN_IDLE;
            cnt     <= '0;
            act_div <= '0;
            div_reg <= '0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            act_div <= act_div_nx;
            if (div_hi_we)
                div_reg[DIV_W-1:HALF] <= div_wdata;
            if (div_lo_we)
                div_reg[HALF-1:0] <= div_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tick16 <= 1'b0;
        else
            tick16 <= fire;
    end

    // R3: the count never leaves the loaded range
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_RUN) |-> (cnt < act_div));
    // R2: the idle state produces no pulse
    p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_IDLE) |=> !tick16);
    // R4: every pulse comes from a prescaler enable
    p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> $past(pre_en));
    // R9: single-cycle pulse when the period exceeds one cycle
    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && act_div > 1) |=> !tick16);
endmodule

// File: rtl/baud_ovs_div.sv
module baud_ovs_div #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic tick1
);
    localparam int SW = $clog2(OVS);

    logic [SW-1:0] sub;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub   <= '0;
            tick1 <= 1'b0;
        end else begin
            tick1 <= fire && (sub == SW'(OVS - 1));
            if (fire)
                sub <= (sub == SW'(OVS - 1)) ? '0 : sub + 1'b1;
        end
    end
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen #(
    parameter int DIV_W = 16,
    parameter int RATIO = 4,
    parameter int OVS   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_div4,
    input  logic               presc_we,
    input  logic               presc_val,
    input  logic               div_hi_we,
    input  logic               div_lo_we,
    input  logic [DIV_W/2-1:0] div_wdata,
    output logic               tick16,
    output logic               tick1
);
    logic pre_en;
    logic fire;

    baud_presc #(.RATIO(RATIO)) u_presc (
        .clk(clk), .rst_n(rst_n), .strap_div4(strap_div4),
        .presc_we(presc_we), .presc_val(presc_val), .pre_en(pre_en)
    );

    baud_divctr #(.DIV_W(DIV_W)) u_divctr (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en),
        .div_hi_we(div_hi_we), .div_lo_we(div_lo_we), .div_wdata(div_wdata),
        .fire(fire), .tick16(tick16)
    );

    baud_ovs_div #(.OVS(OVS)) u_ovs (
        .clk(clk), .rst_n(rst_n), .fire(fire), .tick1(tick1)
    );

    // R10: the bit-rate enable coincides with an oversampling enable
    p_tick1_on_tick16_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |-> tick16);
endmodule

// File: tb/baud_rate_gen_test.sv
module baud_rate_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_div4 = 1'b0;
    logic       presc_we = 1'b0;
    logic       presc_val = 1'b0;
    logic       div_hi_we = 1'b0;
    logic       div_lo_we = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       tick16, tick1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_rate_gen uut (
        .clk(clk), .rst_n(rst_n), .strap_div4(strap_div4),
        .presc_we(presc_we), .presc_val(presc_val),
        .div_hi_we(div_hi_we), .div_lo_we(div_lo_we), .div_wdata(div_wdata),
        .tick16(tick16), .tick1(tick1)
    );

    function automatic int exp_period(input bit div4, input int d);
        return (div4 ? 4 : 1) * d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_div4 = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_div(input int d);
        @(negedge clk);
        div_hi_we = 1'b1; div_wdata = 8'(d >> 8);
        @(negedge clk);
        div_hi_we = 1'b0; div_lo_we = 1'b1; div_wdata = 8'(d);
        @(negedge clk);
        div_lo_we = 1'b0;
    endtask

    task automatic wr_presc(input bit v);
        @(negedge clk);
        presc_we = 1'b1; presc_val = v;
        @(negedge clk);
        presc_we = 1'b0;
    endtask

    task automatic wait16;
        do @(negedge clk); while (!tick16);
    endtask

    task automatic interval16(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick16);
    endtask

    task automatic check16(input string req, input int exp);
        int n;
        wait16; wait16;
        interval16(n); chk(req, n, exp);
        interval16(n); chk(req, n, exp);
    endtask

    // R10 and R9: tick1 period, coincidence and pulse width
    task automatic check1(input int e16);
        int n;
        do @(negedge clk); while (!tick1);
        chk("R10 tick16 with tick1", int'(tick16), 1);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick1);
        chk("R10 tick1 period", n, 16 * e16);
        if (e16 > 1) begin
            @(negedge clk);
            chk("R9 pulse width", int'(tick16), 0);
        end
    endtask

    initial begin
        int cnt, n;
        void'($urandom(32'd7741));

        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 tick16 in reset", int'(tick16), 0);
        chk("R1 tick1 in reset", int'(tick1), 0);
        rst_n = 1'b1;

        // R2: divisor zero after reset -> silence
        cnt = 0;
        repeat (200) begin @(negedge clk); cnt += int'(tick16) + int'(tick1); end
        chk("R1 R2 silent after reset", cnt, 0);

        // R3: divide-by-1 default from strap 0
        wr_div(1);
        check16("R3 div1", 1);
        check1(1);
        wr_div(3);
        check16("R3 div3", exp_period(0, 3));

        // R5: strap 1 selects divide-by-4
        do_reset(1'b1);
        wr_div(3);
        check16("R5 R4 strap div4", exp_period(1, 3));
        check1(exp_period(1, 3));

        // R6: runtime override back to divide-by-1 and again to divide-by-4
        wr_presc(1'b0);
        check16("R6 override div1", exp_period(0, 3));
        wr_presc(1'b1);
        check16("R6 override div4", exp_period(1, 3));

        // R8: mid-interval write finishes the old interval
        do_reset(1'b0);
        wr_div(5);
        wait16; wait16;
        n = 0;
        div_lo_we = 1'b1; div_wdata = 8'd9;
        @(negedge clk); n++;
        div_lo_we = 1'b0;
        while (!tick16) begin @(negedge clk); n++; end
        chk("R8 old interval kept", n, 5);
        interval16(n);
        chk("R8 new interval", n, 9);

        // R2: writing zero stops the generator
        wr_div(0);
        repeat (40) @(negedge clk);
        cnt = 0;
        repeat (300) begin @(negedge clk); cnt += int'(tick16) + int'(tick1); end
        chk("R2 divisor zero silent", cnt, 0);

        // Random divisors and prescale settings
        for (int i = 0; i < 8; i++) begin
            int d;
            bit p;
            d = 1 + int'($urandom_range(11));
            p = bit'($urandom_range(1));
            wr_presc(p);
            wr_div(d);
            check16(p ? "R4 random" : "R3 random", exp_period(p, d));
            check1(exp_period(p, d));
        end

        // R7: high-byte divisor 0x0900 with divide-by-4
        wr_presc(1'b1);
        wr_div(16'h0900);
        wait16;
        interval16(n);
        chk("R7 divisor 0x0900", n, exp_period(1, 2304));
        interval16(n);
        chk("R7 divisor 0x0900", n, 9216);

        done = 1;
    end

    initial begin
        wait (done || cyc > 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule